// File: doc/BRIEF.md
# Double-Buffered Pixel Non-Uniformity Correction

This block corrects a streaming focal-plane pixel stream one pixel per clock. Every pixel position in the frame owns a coefficient word: an offset, a gain and a defect flag. The word is read from on-chip storage in lockstep with the incoming pixel, the offset is removed, the result is scaled by the gain and saturated, and pixels flagged as defective are replaced by the last good value on their line.

Coefficients live in two banks. The active bank feeds the datapath. A slow background loader, standing in for a flash reader, writes the next set into the other (shadow) bank. The caller picks which stored set the loader fetches (for example from the sensor temperature) and tags the final word with that set number. After the final word the swap is pending. It happens at the next start-of-frame, so a frame is never corrected with a partly written set.

Top module: `nuc_stream_top`

## Requirements
- R1: Each output pixel equals min(2^14-1, (max(0, pix - off) * gain) >> 14), where the coefficient word carries off in bits 13:0, the unsigned Q2.14 gain in bits 29:14 and the defect flag in bit 30.
- R2: Output data lag the input by exactly 2 clock cycles, and out_valid, out_sof and out_eol are delayed by the same amount.
- R3: The coefficient used for a pixel is the word at address n, where n is the pixel's index since the last accepted pixel with in_sof set (that pixel is index 0).
- R4: Loader writes go only into the shadow bank. Frames that arrive while a load is under way are corrected with the current active set.
- R5: After a load ends (ld_valid with ld_last), the next accepted in_sof pixel is already corrected with the new set. On that cycle act_bank toggles and act_set takes the ld_set value captured with the final word.
- R6: A start-of-frame with no pending load leaves act_bank and act_set unchanged.
- R7: A start-of-frame that comes while a load is still in progress does not swap. A new load that begins while a swap is pending cancels that swap, and only the final word of the new load arms it again.
- R8: ld_busy is 1 from the cycle after the first loader word until the swap executes, and 0 otherwise.
- R9: A pixel whose defect flag is 1, and which is not the first pixel of its line, is output as the previous output pixel of the same line.
- R10: A defective pixel that opens a line (the first pixel after reset, after a pixel with in_eol, or a pixel with in_sof) is output as 0.
- R11: After reset out_valid, act_bank, act_set and ld_busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_pix | input | 14 | Raw pixel |
| ld_valid | input | 1 | Loader word valid |
| ld_addr | input | 6 | Pixel index of the loader word |
| ld_word | input | 31 | Coefficient word {defect, gain, offset} |
| ld_last | input | 1 | Final word of the load |
| ld_set | input | 3 | Set number, captured with the final word |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Delayed start-of-frame |
| out_eol | output | 1 | Delayed end-of-line |
| out_pix | output | 14 | Corrected pixel |
| act_bank | output | 1 | Bank currently feeding the datapath |
| act_set | output | 3 | Set number held in the active bank |
| ld_busy | output | 1 | Load in progress or swap pending |

## Verification
On every cycle the assertions check the two-cycle marker alignment, that the active bank only changes on a start-of-frame, that a frame start while loading or idle leaves the bank alone, that loader writes never hit the bank being read, and the zero and hold outputs for flagged pixels. Only the bench's scenarios show the arithmetic against a vector table, that every pixel of a frame uses its own coefficient word, and the full load, defer, cancel and swap sequence seen through act_set and the corrected frames.

// File: rtl/nuc_pkg.sv
package nuc_pkg;
   typedef struct packed {
      logic valid;
      logic sof;
      logic eol;
   } nuc_mark_t;

   localparam int NUC_PIX_W_DEF     = 14;
   localparam int NUC_GAIN_W_DEF    = 16;
   localparam int NUC_GAIN_FRAC_DEF = 14;
endpackage

// File: rtl/nuc_bank_ctrl.sv
module nuc_bank_ctrl #(
   parameter int SET_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof_strobe,
   input  logic             ld_valid,
   input  logic             ld_last,
   input  logic [SET_W-1:0] ld_set,
   output logic             act_bank,
   output logic             rd_bank,
   output logic             wr_bank,
   output logic [SET_W-1:0] act_set,
   output logic             ld_busy
);
   logic             loading;
   logic             pend;
   logic [SET_W-1:0] staged_set;
   logic             swap_now;

   assign swap_now = sof_strobe & pend & ~loading & ~ld_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loading    <= 1'b0;
         pend       <= 1'b0;
         staged_set <= '0;
         act_bank   <= 1'b0;
         act_set    <= '0;
      end else if (ld_valid) begin
         loading <= ~ld_last;
         pend    <= ld_last;
         if (ld_last) staged_set <= ld_set;
      end else if (swap_now) begin
         pend     <= 1'b0;
         act_bank <= ~act_bank;
         act_set  <= staged_set;
      end
   end

   assign rd_bank = swap_now ? ~act_bank : act_bank;
   assign wr_bank = ~act_bank;
   assign ld_busy = loading | pend;

   assert_swap_on_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_bank) |-> $past(sof_strobe));
   assert_idle_sof_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_strobe && !ld_busy) |=> ($stable(act_bank) && $stable(act_set)));
   assert_loading_defers_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_strobe && loading) |=> $stable(act_bank));
   assert_busy_after_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> ld_busy);
endmodule

// File: rtl/nuc_coef_store.sv
module nuc_coef_store #(
   parameter int NPIX   = 64,
   parameter int COEF_W = 31,
   localparam int ADDR_W = $clog2(NPIX)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [COEF_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_bank,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [COEF_W-1:0] rd_data
);
   logic sel_q;
   logic [COEF_W-1:0] bank_q [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [COEF_W-1:0] mem [NPIX];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
         if (rd_en && (rd_bank == 1'(b))) bank_q[b] <= mem[rd_addr];
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) sel_q <= rd_bank;
   end

   assign rd_data = bank_q[sel_q];
endmodule

// File: rtl/nuc_pixel_path.sv
module nuc_pixel_path
   import nuc_pkg::*;
#(
   parameter int PIX_W     = NUC_PIX_W_DEF,
   parameter int GAIN_W    = NUC_GAIN_W_DEF,
   parameter int GAIN_FRAC = NUC_GAIN_FRAC_DEF,
   parameter bit DEFECT_EN = 1'b1,
   localparam int COEF_W = 1 + GAIN_W + PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  nuc_mark_t         in_mk,
   input  logic [PIX_W-1:0]  in_pix,
   input  logic [COEF_W-1:0] coef,
   output nuc_mark_t         out_mk,
   output logic [PIX_W-1:0]  out_pix
);
   localparam int PROD_W = PIX_W + GAIN_W;
   localparam int SH_W   = PROD_W - GAIN_FRAC;

   nuc_mark_t         s1_mk;
   logic [PIX_W-1:0]  s1_pix;
   logic              s1_first;
   logic              line_fresh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_mk      <= '0;
         s1_pix     <= '0;
         s1_first   <= 1'b0;
         line_fresh <= 1'b1;
      end else begin
         s1_mk <= in_mk;
         if (in_mk.valid) begin
            s1_pix     <= in_pix;
            s1_first   <= in_mk.sof | line_fresh;
            line_fresh <= in_mk.eol;
         end
      end
   end

   logic [PIX_W-1:0]  off;
   logic [GAIN_W-1:0] gain;
   logic              defect;
   logic [PIX_W:0]    diff;
   logic [PIX_W-1:0]  mag;
   logic [PROD_W-1:0] prod;
   logic [SH_W-1:0]   shifted;
   logic [PIX_W-1:0]  corr;
   logic [PIX_W-1:0]  fixed;

   always_comb begin
      off     = coef[PIX_W-1:0];
      gain    = coef[PIX_W +: GAIN_W];
      defect  = coef[COEF_W-1];
      diff    = {1'b0, s1_pix} - {1'b0, off};
      mag     = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
      prod    = PROD_W'(mag) * PROD_W'(gain);
      shifted = SH_W'(prod >> GAIN_FRAC);
      corr    = (|shifted[SH_W-1:PIX_W]) ? '1 : shifted[PIX_W-1:0];
   end

   if (DEFECT_EN) begin : g_defect
      always_comb begin
         if (defect) fixed = s1_first ? '0 : out_pix;
         else        fixed = corr;
      end

      assert_line_head_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (s1_mk.valid && defect && s1_first) |=> (out_pix == '0));
      assert_defect_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (s1_mk.valid && defect && !s1_first) |=> $stable(out_pix));
   end else begin : g_plain
      assign fixed = corr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_mk  <= '0;
         out_pix <= '0;
      end else begin
         out_mk <= s1_mk;
         if (s1_mk.valid) out_pix <= fixed;
      end
   end
endmodule

// File: rtl/nuc_stream_top.sv
module nuc_stream_top
   import nuc_pkg::*;
#(
   parameter int PIX_W     = NUC_PIX_W_DEF,
   parameter int GAIN_W    = NUC_GAIN_W_DEF,
   parameter int GAIN_FRAC = NUC_GAIN_FRAC_DEF,
   parameter int NPIX      = 64,
   parameter int SET_W     = 3,
   parameter bit DEFECT_EN = 1'b1,
   localparam int ADDR_W = $clog2(NPIX),
   localparam int COEF_W = 1 + GAIN_W + PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eol,
   input  logic [PIX_W-1:0]  in_pix,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [COEF_W-1:0] ld_word,
   input  logic              ld_last,
   input  logic [SET_W-1:0]  ld_set,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_eol,
   output logic [PIX_W-1:0]  out_pix,
   output logic              act_bank,
   output logic [SET_W-1:0]  act_set,
   output logic              ld_busy
);
   if (GAIN_FRAC >= GAIN_W) begin : g_bad_frac
      $error("gain needs integer bits above its fraction");
   end
   if ((1 << ADDR_W) != NPIX || NPIX < 2) begin : g_bad_npix
      $error("frame pixel count must be a power of two, at least 2");
   end
   if (PIX_W < 2 || SET_W < 1) begin : g_bad_width
      $error("pixel or set width too small");
   end

   logic              sof_strobe;
   logic              rd_bank;
   logic              wr_bank;
   logic [ADDR_W-1:0] pix_idx;
   logic [ADDR_W-1:0] rd_addr;
   logic [COEF_W-1:0] coef;
   nuc_mark_t         in_mk;
   nuc_mark_t         out_mk;

   assign sof_strobe = in_valid & in_sof;
   assign rd_addr    = in_sof ? '0 : pix_idx;
   assign in_mk      = '{valid: in_valid, sof: in_sof, eol: in_eol};

   always_ff @(posedge clk) begin
      if (!rst_n)        pix_idx <= '0;
      else if (in_valid) pix_idx <= rd_addr + ADDR_W'(1);
   end

   nuc_bank_ctrl #(.SET_W(SET_W)) bank_ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof_strobe (sof_strobe),
      .ld_valid   (ld_valid),
      .ld_last    (ld_last),
      .ld_set     (ld_set),
      .act_bank   (act_bank),
      .rd_bank    (rd_bank),
      .wr_bank    (wr_bank),
      .act_set    (act_set),
      .ld_busy    (ld_busy)
   );

   nuc_coef_store #(.NPIX(NPIX), .COEF_W(COEF_W)) coef_store_i (
      .clk     (clk),
      .wr_en   (ld_valid),
      .wr_bank (wr_bank),
      .wr_addr (ld_addr),
      .wr_data (ld_word),
      .rd_en   (in_valid),
      .rd_bank (rd_bank),
      .rd_addr (rd_addr),
      .rd_data (coef)
   );

   nuc_pixel_path #(
      .PIX_W     (PIX_W),
      .GAIN_W    (GAIN_W),
      .GAIN_FRAC (GAIN_FRAC),
      .DEFECT_EN (DEFECT_EN)
   ) pixel_path_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_mk   (in_mk),
      .in_pix  (in_pix),
      .coef    (coef),
      .out_mk  (out_mk),
      .out_pix (out_pix)
   );

   assign out_valid = out_mk.valid;
   assign out_sof   = out_mk.sof;
   assign out_eol   = out_mk.eol;

   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);
   assert_sof_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |-> ##2 (out_valid && out_sof));
   assert_eol_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eol) |-> ##2 (out_valid && out_eol));
   assert_frame_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (pix_idx == ADDR_W'(1)));
   assert_shadow_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && in_valid) |-> (wr_bank != rd_bank));
endmodule

// File: tb/nuc_stream_top_tb.sv
module nuc_stream_top_tb_top;
   localparam int NPIX  = 64;
   localparam int LINE  = 8;
   localparam int PIX_W = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
   logic [13:0] in_pix = '0;
   logic        ld_valid = 1'b0, ld_last = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [30:0] ld_word = '0;
   logic [2:0]  ld_set = '0;
   logic        out_valid, out_sof, out_eol, act_bank, ld_busy;
   logic [13:0] out_pix;
   logic [2:0]  act_set;

   always #2 clk = ~clk;

   nuc_stream_top dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
      .in_pix(in_pix), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_word(ld_word),
      .ld_last(ld_last), .ld_set(ld_set), .out_valid(out_valid), .out_sof(out_sof),
      .out_eol(out_eol), .out_pix(out_pix), .act_bank(act_bank), .act_set(act_set),
      .ld_busy(ld_busy)
   );

   // {pix, offset, gain, expected}
   localparam logic [57:0] VEC [8] = '{
      {14'd1000,  14'd100,   16'h4000, 14'd900},
      {14'd100,   14'd200,   16'h4000, 14'd0},
      {14'd16383, 14'd0,     16'h8000, 14'd16383},
      {14'd3000,  14'd1000,  16'h2000, 14'd1000},
      {14'd5000,  14'd0,     16'h6000, 14'd7500},
      {14'd16383, 14'd16383, 16'hFFFF, 14'd0},
      {14'd10000, 14'd1,     16'hFFFF, 14'd16383},
      {14'd4097,  14'd1,     16'h6000, 14'd6144}
   };

   int checks = 0, errors = 0, cyc = 0;
   bit done = 1'b0;
   logic [30:0] words [NPIX];
   logic [13:0] pix_in [NPIX];
   int exp_pix [NPIX];
   int cap_pix [NPIX];
   bit cap_eol [NPIX];
   int cap_n = 0, in_sof_cyc = 0, out_sof_cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (out_sof) begin
            cap_n = 0;
            out_sof_cyc = cyc;
         end
         cap_pix[cap_n % NPIX] = int'(out_pix);
         cap_eol[cap_n % NPIX] = out_eol;
         cap_n++;
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model_corr(int pix, logic [30:0] w);
      longint d, v;
      d = longint'(pix) - longint'(w[13:0]);
      if (d < 0) return 0;
      v = (d * longint'(w[29:14])) >>> 14;
      if (v > 16383) v = 16383;
      return int'(v);
   endfunction

   function automatic void build_exp();
      int last = 0;
      for (int i = 0; i < NPIX; i++) begin
         int e;
         if (words[i][30]) e = ((i % LINE) == 0) ? 0 : last;
         else              e = model_corr(int'(pix_in[i]), words[i]);
         exp_pix[i] = e;
         last = e;
      end
   endfunction

   task automatic load_words(input int lo, input int hi, input bit fin, input logic [2:0] s,
                             input logic [30:0] w [NPIX]);
      for (int i = lo; i <= hi; i++) begin
         @(negedge clk);
         ld_valid = 1'b1;
         ld_addr  = 6'(i);
         ld_word  = w[i];
         ld_last  = fin && (i == hi);
         ld_set   = s;
      end
      @(negedge clk);
      ld_valid = 1'b0;
      ld_last  = 1'b0;
   endtask

   task automatic send_frame(input bit gaps);
      for (int i = 0; i < NPIX; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eol   = ((i % LINE) == LINE - 1);
         in_pix   = pix_in[i];
         if (i == 0) in_sof_cyc = cyc;
         if (gaps && in_eol) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
            in_eol   = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eol   = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_frame(string req);
      check({req, " pixel count"}, cap_n, NPIX);
      for (int i = 0; i < NPIX; i++) begin
         check(req, cap_pix[i], exp_pix[i]);
         check("R2 eol alignment", int'(cap_eol[i]), int'((i % LINE) == LINE - 1));
      end
   endtask

   logic [30:0] set_a [NPIX];
   logic [30:0] set_b [NPIX];
   logic [30:0] set_c [NPIX];
   logic [30:0] set_d [NPIX];
   logic [13:0] pix_tab [NPIX];
   logic [13:0] pix_ramp [NPIX];

   initial begin
      for (int i = 0; i < NPIX; i++) begin
         logic [57:0] v;
         bit bad;
         v = VEC[i % 8];
         set_a[i]    = {1'b0, v[29:14], v[43:30]};
         pix_tab[i]  = v[57:44];
         pix_ramp[i] = 14'(i * 37 + 5);
         bad = (i == 0) || (i == 9) || (i == 10) || (i == 16) || (i == 23);
         set_b[i] = {bad, 16'h4000, 14'd3};
         set_c[i] = {1'b0, 16'h8000, 14'd0};
         set_d[i] = {1'b0, 16'h2000, 14'd0};
      end

      repeat (3) @(negedge clk);
      check("R11 out_valid after reset", int'(out_valid), 0);
      check("R11 act_bank after reset", int'(act_bank), 0);
      check("R11 act_set after reset", int'(act_set), 0);
      check("R11 ld_busy after reset", int'(ld_busy), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: set 1 loaded fully, swapped on the next frame (R1, R3, R5, R8)
      load_words(0, NPIX - 1, 1'b1, 3'd1, set_a);
      check("R8 busy while swap pending", int'(ld_busy), 1);
      check("R5 no swap before frame", int'(act_bank), 0);
      pix_in = pix_tab;
      send_frame(1'b0);
      check("R2 sof latency", out_sof_cyc - in_sof_cyc, 2);
      for (int i = 0; i < NPIX; i++) begin
         logic [57:0] v;
         v = VEC[i % 8];
         check("R1 R3 table vector", cap_pix[i], int'(v[13:0]));
      end
      check("R5 act_bank after swap", int'(act_bank), 1);
      check("R5 act_set after swap", int'(act_set), 1);
      check("R8 busy clears at swap", int'(ld_busy), 0);

      // Idle frame with line gaps: nothing pending (R6)
      words = set_a;
      pix_in = pix_ramp;
      build_exp();
      send_frame(1'b1);
      check_frame("R6 idle frame keeps set");
      check("R6 act_bank unchanged", int'(act_bank), 1);
      check("R6 act_set unchanged", int'(act_set), 1);

      // Half-loaded set 2: frame must still use set 1 (R4, R7)
      load_words(0, NPIX / 2 - 1, 1'b0, 3'd2, set_b);
      check("R8 busy during load", int'(ld_busy), 1);
      send_frame(1'b0);
      check_frame("R4 R7 frame during load");
      check("R7 act_bank held during load", int'(act_bank), 1);
      load_words(NPIX / 2, NPIX - 1, 1'b1, 3'd2, set_b);

      // Set 2 with defective pixels (R9, R10)
      words = set_b;
      build_exp();
      send_frame(1'b1);
      check_frame("R9 R10 defect frame");
      check("R10 line-head defect", cap_pix[16], 0);
      check("R9 defect repeats neighbour", cap_pix[10], exp_pix[8]);
      check("R5 act_set 2", int'(act_set), 2);
      check("R5 act_bank 0", int'(act_bank), 0);

      // Pending set 3 cancelled by a new load of set 4 (R7)
      load_words(0, NPIX - 1, 1'b1, 3'd3, set_c);
      load_words(0, 3, 1'b0, 3'd4, set_d);
      send_frame(1'b0);
      check_frame("R7 cancelled swap keeps set 2");
      check("R7 act_set still 2", int'(act_set), 2);
      load_words(4, NPIX - 1, 1'b1, 3'd4, set_d);
      words = set_d;
      build_exp();
      send_frame(1'b0);
      check_frame("R7 new set after final word");
      check("R7 act_set 4", int'(act_set), 4);
      check("R8 busy idle", int'(ld_busy), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule